// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a load/store RISC core's datapath. In a single combinational pass it moves a 32-bit source word left or right by an 8-bit amount. The four operations are logical left, logical right, arithmetic right and rotate right. Alongside the shifted word it produces the shifter carry, which the ALU uses for logical operations.

Shift amounts from 33 up to 255 are legal and have exact results; they are not folded into a 5-bit range. The caller may also ask the block to produce new condition flags from the result. When it does not ask, the incoming flags are handed back unchanged. Any reinterpretation of immediate shift fields, such as an encoded zero that stands for 32 or rotate-through-carry, is done by the decoder before this block. There is no clock and no state.

Top module: `shft_barrel`

## Requirements
- R1: When the amount is 0, the result equals the source and the shifter carry equals `carry_i`, for every operation.
- R2: Logical left (op 2'b00). For amounts 1 to 32 the carry is source bit (32 - amount); above 32 it is 0. The result is the source shifted left with zero fill, and it is 0 for any amount of 32 or more.
- R3: Logical right (op 2'b01). For amounts 1 to 32 the carry is source bit (amount - 1); above 32 it is 0. The result is the source shifted right with zero fill, and it is 0 for any amount of 32 or more.
- R4: Arithmetic right (op 2'b10). Vacated bits take a copy of source bit 31. For amounts 1 to 32 the carry is source bit (amount - 1); above 32 it is source bit 31. For any amount of 32 or more, the result is 32 copies of source bit 31.
- R5: Rotate right (op 2'b11). The source is rotated by the amount modulo 32. For any nonzero amount the carry equals result bit 31, and this includes multiples of 32.
- R6: The operation code is decoded as 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R7: With `upd_flags_i` high, `neg_o` is result bit 31, `zero_o` is 1 exactly when the result is zero, and `carry_o` is the shifter carry.
- R8: With `upd_flags_i` low, `neg_o`, `zero_o` and `carry_o` equal `neg_i`, `zero_i` and `carry_i`, whatever the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Source word |
| amt_i | input | 8 | Shift amount, 0 to 255 |
| op_i | input | 2 | Operation select (R6 encoding) |
| carry_i | input | 1 | Incoming carry flag |
| neg_i | input | 1 | Incoming negative flag |
| zero_i | input | 1 | Incoming zero flag |
| upd_flags_i | input | 1 | Produce new flags from the result |
| result_o | output | 32 | Shifted word |
| shcarry_o | output | 1 | Shifter carry-out |
| neg_o | output | 1 | Negative flag out |
| zero_o | output | 1 | Zero flag out |
| carry_o | output | 1 | Carry flag out |

## Verification
The checker holds continuously for every input combination. It covers the zero-amount pass-through, the all-zero results of both logical shifts at 32 and above, the sign fill of the arithmetic shift, and the tie between rotate carry and result bit 31. It also covers both flag paths.

Only the bench's scenarios can show that the exact bit selected as carry for amounts 1 to 32 is right, and that the shifted word itself is right at each amount. To do this, the bench compares every operation at amounts 0 to 40 and 255 against a bit-serial model. It also checks a small set of hand-worked vectors.

// File: rtl/shft_pkg.sv
package shft_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shop_e;
endpackage

// File: rtl/shft_core.sv
module shft_core
  import shft_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  src,
  input  logic [AW-1:0] amt,
  input  logic [1:0]    op,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  localparam int RW = $clog2(W);

  // Each function returns {carry, result}; a zero amount is handled by the caller.
  function automatic logic [W:0] f_lsl(input logic [W-1:0] s, input logic [AW-1:0] a);
    logic [2*W-1:0] t;
    t = {{W{1'b0}}, s} << a;
    return {t[W], t[W-1:0]};
  endfunction

  function automatic logic [W:0] f_lsr(input logic [W-1:0] s, input logic [AW-1:0] a);
    logic [2*W-1:0] t;
    t = {s, {W{1'b0}}} >> a;
    return {t[W-1], t[2*W-1:W]};
  endfunction

  function automatic logic [W:0] f_asr(input logic [W-1:0] s, input logic [AW-1:0] a);
    logic signed [2*W-1:0] t;
    t = $signed({s, {W{1'b0}}}) >>> a;
    return {t[W-1], t[2*W-1:W]};
  endfunction

  function automatic logic [W:0] f_ror(input logic [W-1:0] s, input logic [AW-1:0] a);
    logic [2*W-1:0] t;
    logic [RW-1:0]  r;
    r = a[RW-1:0];
    t = {s, s} >> r;
    return {t[W-1], t[W-1:0]};
  endfunction

  logic [W:0] lane [4];

  always_comb begin
    lane[0] = f_lsl(src, amt);
    lane[1] = f_lsr(src, amt);
    lane[2] = f_asr(src, amt);
    lane[3] = f_ror(src, amt);
  end

  always_comb begin
    if (amt == '0) begin
      res  = src;
      cout = cin;
    end else begin
      {cout, res} = lane[op];
    end
  end
endmodule

// File: rtl/shft_flags.sv
module shft_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         shc,
  input  logic         upd,
  input  logic         n_in,
  input  logic         z_in,
  input  logic         c_in,
  output logic         n_out,
  output logic         z_out,
  output logic         c_out
);
  always_comb begin
    if (upd) begin
      n_out = res[W-1];
      z_out = ~|res;
      c_out = shc;
    end else begin
      n_out = n_in;
      z_out = z_in;
      c_out = c_in;
    end
  end
endmodule

// File: rtl/shft_barrel.sv
module shft_barrel
  import shft_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [31:0] src_i,
  input  logic [7:0]  amt_i,
  input  logic [1:0]  op_i,
  input  logic        carry_i,
  input  logic        neg_i,
  input  logic        zero_i,
  input  logic        upd_flags_i,
  output logic [31:0] result_o,
  output logic        shcarry_o,
  output logic        neg_o,
  output logic        zero_o,
  output logic        carry_o
);
  logic [W-1:0] sh_res;
  logic         sh_carry;

  shft_core #(.W(W), .AW(AW)) u_core (
    .src  (src_i),
    .amt  (amt_i),
    .op   (op_i),
    .cin  (carry_i),
    .res  (sh_res),
    .cout (sh_carry)
  );

  shft_flags #(.W(W)) u_flags (
    .res   (sh_res),
    .shc   (sh_carry),
    .upd   (upd_flags_i),
    .n_in  (neg_i),
    .z_in  (zero_i),
    .c_in  (carry_i),
    .n_out (neg_o),
    .z_out (zero_o),
    .c_out (carry_o)
  );

  assign result_o  = sh_res;
  assign shcarry_o = sh_carry;
endmodule

// File: rtl/shft_barrel_chk.sv
module shft_barrel_chk #(
  parameter int W = 32
) (
  input logic [31:0] src_i,
  input logic [7:0]  amt_i,
  input logic [1:0]  op_i,
  input logic        carry_i,
  input logic        neg_i,
  input logic        zero_i,
  input logic        upd_flags_i,
  input logic [31:0] sh_res,
  input logic        sh_carry,
  input logic        neg_o,
  input logic        zero_o,
  input logic        carry_o
);
  always_comb begin
    if (amt_i == 8'd0)
      a_r1_zero_amount: assert (sh_res == src_i && sh_carry == carry_i)
        else $error("R1 zero amount");
    if (op_i == 2'b00 && int'(amt_i) >= W)
      a_r2_lsl_wide: assert (sh_res == '0 && (int'(amt_i) == W || !sh_carry))
        else $error("R2 lsl wide");
    if (op_i == 2'b01 && int'(amt_i) >= W)
      a_r3_lsr_wide: assert (sh_res == '0 && (int'(amt_i) == W || !sh_carry))
        else $error("R3 lsr wide");
    if (op_i == 2'b10 && int'(amt_i) >= W)
      a_r4_asr_fill: assert (sh_res == {W{src_i[W-1]}} && (int'(amt_i) == W || sh_carry == src_i[W-1]))
        else $error("R4 asr fill");
    if (op_i == 2'b11 && amt_i != 8'd0)
      a_r5_ror_carry: assert (sh_carry == sh_res[W-1])
        else $error("R5 ror carry");
    if (upd_flags_i)
      a_r7_flags_new: assert (neg_o == sh_res[W-1] && zero_o == (sh_res == '0) && carry_o == sh_carry)
        else $error("R7 flags");
    else
      a_r8_flags_hold: assert (neg_o == neg_i && zero_o == zero_i && carry_o == carry_i)
        else $error("R8 flags hold");
  end
endmodule

bind shft_barrel shft_barrel_chk #(.W(W)) u_chk (
  .src_i       (src_i),
  .amt_i       (amt_i),
  .op_i        (op_i),
  .carry_i     (carry_i),
  .neg_i       (neg_i),
  .zero_i      (zero_i),
  .upd_flags_i (upd_flags_i),
  .sh_res      (sh_res),
  .sh_carry    (sh_carry),
  .neg_o       (neg_o),
  .zero_o      (zero_o),
  .carry_o     (carry_o)
);

// File: tb/test_shft_barrel.sv
module test_shft_barrel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] src;
  logic [7:0]  amt;
  logic [1:0]  op;
  logic        cin, nin, zin, upd;
  logic [31:0] res;
  logic        shc, nout, zout, cout;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  shft_barrel i_shft_barrel (
    .src_i(src), .amt_i(amt), .op_i(op), .carry_i(cin),
    .neg_i(nin), .zero_i(zin), .upd_flags_i(upd),
    .result_o(res), .shcarry_o(shc), .neg_o(nout), .zero_o(zout), .carry_o(cout)
  );

  // Hand-worked vectors: {op, amt, cin, src, expected result, expected carry}
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  amt;
    logic        cin;
    logic [31:0] src;
    logic [31:0] res;
    logic        c;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 8'd1,   1'b0, 32'h8000_0001, 32'h0000_0002, 1'b1},
    '{2'b01, 8'd1,   1'b0, 32'h8000_0001, 32'h4000_0000, 1'b1},
    '{2'b10, 8'd4,   1'b1, 32'h8000_0000, 32'hF800_0000, 1'b0},
    '{2'b11, 8'd1,   1'b0, 32'h0000_0001, 32'h8000_0000, 1'b1},
    '{2'b11, 8'd32,  1'b0, 32'h8765_4321, 32'h8765_4321, 1'b1},
    '{2'b00, 8'd32,  1'b0, 32'h0000_0001, 32'h0000_0000, 1'b1},
    '{2'b01, 8'd32,  1'b0, 32'h8000_0000, 32'h0000_0000, 1'b1},
    '{2'b10, 8'd200, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1},
    '{2'b00, 8'd33,  1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{2'b01, 8'd0,   1'b1, 32'h0000_0005, 32'h0000_0005, 1'b1}
  };

  // Bit-serial model of the requirements: one position per step.
  function automatic logic [32:0] model(input logic [1:0] o, input logic [7:0] a,
                                        input logic ci, input logic [31:0] s);
    logic [31:0] r;
    logic        c;
    r = s;
    c = ci;
    if (o == 2'b11) begin
      for (int i = 0; i < (int'(a) % 32); i++) r = {r[0], r[31:1]};
      if (a != 0) c = r[31];
    end else begin
      for (int i = 0; i < int'(a); i++) begin
        case (o)
          2'b00:   begin c = r[31]; r = {r[30:0], 1'b0}; end
          2'b01:   begin c = r[0];  r = {1'b0, r[31:1]}; end
          default: begin c = r[0];  r = {r[31], r[31:1]}; end
        endcase
      end
    end
    return {c, r};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%0d amt=%0d src=%h actual=%h expected=%h", req, op, amt, src, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [7:0] a, input logic ci,
                       input logic [31:0] s, input logic u);
    @(negedge clk);
    op = o; amt = a; cin = ci; src = s; upd = u;
    #5;
  endtask

  function automatic string req_of(input logic [1:0] o, input logic [7:0] a);
    if (a == 0) return "R1";
    case (o)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  localparam logic [31:0] SRCS [4] = '{32'hDEAD_BEEF, 32'h8000_0001, 32'h7FFF_FFFE, 32'h0000_0000};

  initial begin
    src = '0; amt = '0; op = '0; cin = 0; nin = 0; zin = 0; upd = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Quiet state: no amount, no flag update
    apply(2'b00, 8'd0, 1'b1, 32'h1234_5678, 1'b0);
    check("R1", res, 32'h1234_5678);
    check("R1", {31'd0, shc}, 32'd1);

    // R6 / R2..R5: hand vectors
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k].op, VEC[k].amt, VEC[k].cin, VEC[k].src, 1'b0);
      check({"R6 vec ", req_of(VEC[k].op, VEC[k].amt)}, res, VEC[k].res);
      check({"R6 vec ", req_of(VEC[k].op, VEC[k].amt)}, {31'd0, shc}, {31'd0, VEC[k].c});
    end

    // Sweep: every op, amounts 0..40 and 255, both carry-in values
    for (int o = 0; o < 4; o++)
      for (int si = 0; si < 4; si++)
        for (int a = 0; a <= 41; a++)
          for (int ci = 0; ci < 2; ci++) begin
            logic [7:0]  av;
            logic [32:0] m;
            av = (a == 41) ? 8'd255 : 8'(a);
            apply(2'(o), av, 1'(ci), SRCS[si], 1'b0);
            m = model(2'(o), av, 1'(ci), SRCS[si]);
            check(req_of(2'(o), av), res, m[31:0]);
            check(req_of(2'(o), av), {31'd0, shc}, {31'd0, m[32]});
          end

    // R7: flags produced from result
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 40; a += 7) begin
        logic [32:0] m;
        nin = 1'b0; zin = 1'b0;
        apply(2'(o), 8'(a), 1'b1, 32'h8000_0001, 1'b1);
        m = model(2'(o), 8'(a), 1'b1, 32'h8000_0001);
        check("R7 neg",   {31'd0, nout}, {31'd0, m[31]});
        check("R7 zero",  {31'd0, zout}, {31'd0, (m[31:0] == 32'd0)});
        check("R7 carry", {31'd0, cout}, {31'd0, m[32]});
      end

    // R8: flags held when not requested, even when the result is zero/negative
    nin = 1'b0; zin = 1'b1;
    apply(2'b00, 8'd31, 1'b0, 32'h0000_0001, 1'b0);
    check("R8 neg",   {31'd0, nout}, 32'd0);
    check("R8 zero",  {31'd0, zout}, 32'd1);
    check("R8 carry", {31'd0, cout}, 32'd0);
    nin = 1'b1; zin = 1'b0;
    apply(2'b01, 8'd40, 1'b1, 32'hFFFF_FFFF, 1'b0);
    check("R8 neg",   {31'd0, nout}, 32'd1);
    check("R8 zero",  {31'd0, zout}, 32'd0);
    check("R8 carry", {31'd0, cout}, 32'd1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule